// File: doc/BRIEF.md
# Dual-Comparator Up-Counting Timer

This block is a free-running up-counter with two comparators. Comparator A holds a full-width match value. Comparator P holds a short value that is weighed against the top bits of the counter, so it sets a coarse period. A two-bit mode input picks one of four behaviours: plain timing, a toggling compare output, pulse-width modulation, or time-stamping of an external edge. The counter value leaves the block through two byte-wide read ports.

In the timer and compare modes, a select input chooses which comparator returns the counter to zero. In PWM mode the period always comes from comparator P. In capture mode the counter simply runs and wraps. One control input gives the output level. In compare mode it is the starting level, and in PWM mode it is the active level. A separate polarity input then inverts both output pins.

The match flags and the capture flag are plain status pins. They carry no handshake: each is a level that lasts one clock, and nothing holds it back. The capture value stays put until the next capture.

Top module: `dual_cmp_timer`

## Requirements
- R1: `cnt_lo` carries counter bits 7..0. `cnt_hi` carries counter bits 9..8 in its bits 1..0, and its bits 7..2 always read zero.
- R2: After reset the counter is 0 and so is `cap_val`. The counter then adds one on every clock unless a clear applies.
- R3: In timer mode (`mode`=0) or compare mode (`mode`=1) with `clr_sel`=1, the counter reads 0 in the cycle after it equalled `cmp_a`.
- R4: In modes 0 and 1 with `clr_sel`=0, the counter reads 0 in the cycle after it equalled `cmp_p`×128 when `cmp_p` is nonzero. When `cmp_p` is zero, the counter wraps from 1023 to 0.
- R5: `clr_sel` has no effect in PWM mode (`mode`=2), where only the `cmp_p` rule of R4 clears the counter. It also has no effect in capture mode (`mode`=3), where the counter only wraps at 1023.
- R6: `flag_a` is high exactly while the counter equals `cmp_a`. `flag_p` is high exactly while `cmp_p` is nonzero and the counter equals `cmp_p`×128.
- R7: In compare mode, the unpolarised output level equals `out_ctl` until the first A match. The level inverts in the cycle after each A match, and it restarts at `out_ctl` whenever the block leaves compare mode.
- R8: In PWM mode, the unpolarised output level equals `out_ctl` while the counter is below `cmp_a`, and equals its complement otherwise.
- R9: In modes 1 and 2, `out_pol`=1 inverts the output pins. In modes 0 and 3 both pins are low, whatever `out_ctl` and `out_pol` are.
- R10: In capture mode, the trigger is `trig_a` when `cap_src`=0 and `trig_b` when `cap_src`=1. The trigger passes through two synchronising flops. On its rising edge, the next clock loads `cap_val` with the counter value seen in the cycle the edge was detected, and `cap_flag` is high for that single following cycle. The input that is not selected is ignored.
- R11: `tout0` and `tout1` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 timer, 1 compare output, 2 PWM, 3 capture |
| clr_sel | input | 1 | Clear source: 1 comparator A, 0 comparator P or wrap |
| out_ctl | input | 1 | Starting level (compare mode) or active level (PWM mode) |
| out_pol | input | 1 | Inverts both output pins when 1 |
| cap_src | input | 1 | Capture trigger select: 0 trig_a, 1 trig_b |
| cmp_a | input | 10 | Comparator A value |
| cmp_p | input | 3 | Comparator P value, compared with counter bits 9..7 |
| trig_a | input | 1 | Asynchronous capture trigger 0 |
| trig_b | input | 1 | Asynchronous capture trigger 1 |
| cnt_lo | output | 8 | Counter bits 7..0 |
| cnt_hi | output | 8 | Counter bits 9..8, upper bits zero |
| tout0 | output | 1 | Timer output pin 0 |
| tout1 | output | 1 | Timer output pin 1 |
| flag_a | output | 1 | Comparator A match |
| flag_p | output | 1 | Comparator P match |
| cap_val | output | 10 | Captured counter value |
| cap_flag | output | 1 | One-cycle capture strobe |

## Verification
The bench builds the block with its defaults: a 10-bit counter and a 3-bit P value. At that width a full 1024-count wrap fits in a short run, and P=1 gives a 129-count period that repeats several times within a few hundred cycles. A small A value makes the compare toggles dense. Together these let clearing, overflow wrap, PWM duty at both extremes and capture timing all be compared against the model cycle by cycle.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_CMP   = 2'd1,
    MODE_PWM   = 2'd2,
    MODE_CAP   = 2'd3
  } tmr_mode_e;

  function automatic logic mode_drives_pin(tmr_mode_e m);
    return (m == MODE_CMP) || (m == MODE_PWM);
  endfunction

  function automatic logic mode_uses_clr_sel(tmr_mode_e m);
    return (m == MODE_TIMER) || (m == MODE_CMP);
  endfunction

endpackage

// File: rtl/dcmp_counter.sv
module dcmp_counter #(
  parameter int CNT_W = 10,
  parameter int P_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dcmp_pkg::tmr_mode_e   mode,
  input  logic                  clr_sel,
  input  logic [CNT_W-1:0]      cmp_a,
  input  logic [P_W-1:0]        cmp_p,
  output logic [CNT_W-1:0]      cnt,
  output logic                  hit_a,
  output logic                  hit_p
);
  import dcmp_pkg::*;

  localparam int LOW_W = CNT_W - P_W;

  logic [CNT_W-1:0] p_point;
  logic             clear;

  assign p_point = {cmp_p, {LOW_W{1'b0}}};
  assign hit_a   = (cnt == cmp_a);
  assign hit_p   = (cmp_p != '0) && (cnt == p_point);

  // Natural wrap covers the overflow case, so only comparator clears appear here.
  always_comb begin
    clear = 1'b0;
    if (mode_uses_clr_sel(mode)) begin
      clear = clr_sel ? hit_a : hit_p;
    end else if (mode == MODE_PWM) begin
      clear = hit_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dcmp_outgen.sv
module dcmp_outgen #(
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dcmp_pkg::tmr_mode_e mode,
  input  logic                out_ctl,
  input  logic                out_pol,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    cmp_a,
  input  logic                hit_a,
  output logic                pin
);
  import dcmp_pkg::*;

  logic flip;
  logic raw;

  // Parity of A matches since compare mode was entered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip <= 1'b0;
    end else if (mode != MODE_CMP) begin
      flip <= 1'b0;
    end else if (hit_a) begin
      flip <= ~flip;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_CMP: raw = out_ctl ^ flip;
      MODE_PWM: raw = (cnt < cmp_a) ? out_ctl : ~out_ctl;
      default:  raw = 1'b0;
    endcase
  end

  assign pin = mode_drives_pin(mode) ? (raw ^ out_pol) : 1'b0;

endmodule

// File: rtl/dcmp_capture.sv
module dcmp_capture #(
  parameter int CNT_W  = 10,
  parameter int N_SYNC = 2,
  parameter int N_SRC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dcmp_pkg::tmr_mode_e  mode,
  input  logic [N_SRC-1:0]     trig,
  input  logic [$clog2(N_SRC)-1:0] src,
  input  logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     cap_val,
  output logic                 cap_flag
);
  import dcmp_pkg::*;

  logic [N_SRC-1:0] sync_q [N_SYNC];
  logic             prev;
  logic             sel;
  logic             rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= trig;
  end

  for (genvar s = 1; s < N_SYNC; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign sel  = sync_q[N_SYNC-1][src];
  assign rise = sel & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= 1'b0;
      cap_val  <= '0;
      cap_flag <= 1'b0;
    end else begin
      prev     <= sel;
      cap_flag <= 1'b0;
      if (mode == MODE_CAP && rise) begin
        cap_val  <= cnt;
        cap_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CNT_W = 10,
  parameter int P_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             clr_sel,
  input  logic             out_ctl,
  input  logic             out_pol,
  input  logic             cap_src,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [P_W-1:0]   cmp_p,
  input  logic             trig_a,
  input  logic             trig_b,
  output logic [7:0]       cnt_lo,
  output logic [7:0]       cnt_hi,
  output logic             tout0,
  output logic             tout1,
  output logic             flag_a,
  output logic             flag_p,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag
);
  import dcmp_pkg::*;

  localparam int N_PINS = 2;

  tmr_mode_e        mode_e;
  logic [CNT_W-1:0] cnt;
  logic             hit_a;
  logic             hit_p;
  logic             pin;
  logic [N_PINS-1:0] pins;

  assign mode_e = tmr_mode_e'(mode);

  dcmp_counter #(.CNT_W(CNT_W), .P_W(P_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .clr_sel(clr_sel),
    .cmp_a(cmp_a), .cmp_p(cmp_p), .cnt(cnt), .hit_a(hit_a), .hit_p(hit_p)
  );

  dcmp_outgen #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .out_ctl(out_ctl),
    .out_pol(out_pol), .cnt(cnt), .cmp_a(cmp_a), .hit_a(hit_a), .pin(pin)
  );

  dcmp_capture #(.CNT_W(CNT_W), .N_SYNC(2), .N_SRC(2)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .trig({trig_b, trig_a}),
    .src(cap_src), .cnt(cnt), .cap_val(cap_val), .cap_flag(cap_flag)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pins[i] = pin;
  end

  assign tout0  = pins[0];
  assign tout1  = pins[1];
  assign flag_a = hit_a;
  assign flag_p = hit_p;
  assign cnt_lo = cnt[7:0];
  assign cnt_hi = 8'(cnt >> 8);

endmodule

// File: rtl/dcmp_checker.sv
module dcmp_checker #(
  parameter int CNT_W = 10,
  parameter int P_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             clr_sel,
  input logic             out_ctl,
  input logic             out_pol,
  input logic [CNT_W-1:0] cmp_a,
  input logic [P_W-1:0]   cmp_p,
  input logic [7:0]       cnt_lo,
  input logic [7:0]       cnt_hi,
  input logic             tout0,
  input logic             tout1,
  input logic             flag_a,
  input logic             flag_p,
  input logic             cap_flag
);
  localparam logic [15:0] MAXV = 16'((1 << CNT_W) - 1);

  logic [15:0] full;
  assign full = {cnt_hi, cnt_lo};

  p_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hi >> (CNT_W - 8)) == 8'd0);

  p_clear_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 2'd1 && clr_sel && flag_a) |=> full == 16'd0);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 2'd1 && !clr_sel && cmp_p == '0 && full == MAXV) |=> full == 16'd0);

  p_flag_p_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_p |-> cmp_p != '0);

  p_cmp_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && flag_a) ##1 (mode == 2'd1 && $stable(out_pol) && $stable(out_ctl))
      |-> tout0 != $past(tout0));

  p_pwm_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && full == 16'd0 && cmp_a != '0) |-> tout0 == (out_ctl ^ out_pol));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |-> !tout0);

  p_cap_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag |=> !cap_flag);

  p_pins_equal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tout0 == tout1);

endmodule

bind dual_cmp_timer dcmp_checker #(.CNT_W(CNT_W), .P_W(P_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .clr_sel(clr_sel), .out_ctl(out_ctl),
  .out_pol(out_pol), .cmp_a(cmp_a), .cmp_p(cmp_p), .cnt_lo(cnt_lo),
  .cnt_hi(cnt_hi), .tout0(tout0), .tout1(tout1), .flag_a(flag_a),
  .flag_p(flag_p), .cap_flag(cap_flag)
);

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;
  localparam int CW = 10;
  localparam int PW = 3;
  localparam int WRAP = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic clr_sel = 1'b0, out_ctl = 1'b0, out_pol = 1'b0, cap_src = 1'b0;
  logic [CW-1:0] cmp_a = '0;
  logic [PW-1:0] cmp_p = '0;
  logic trig_a = 1'b0, trig_b = 1'b0;
  logic [7:0] cnt_lo, cnt_hi;
  logic tout0, tout1, flag_a, flag_p, cap_flag;
  logic [CW-1:0] cap_val;

  dual_cmp_timer #(.CNT_W(CW), .P_W(PW)) i_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clr_sel(clr_sel), .out_ctl(out_ctl),
    .out_pol(out_pol), .cap_src(cap_src), .cmp_a(cmp_a), .cmp_p(cmp_p),
    .trig_a(trig_a), .trig_b(trig_b), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .tout0(tout0), .tout1(tout1), .flag_a(flag_a), .flag_p(flag_p),
    .cap_val(cap_val), .cap_flag(cap_flag)
  );

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0, first = 0;

  // Reference model state
  int m_cnt, m_par, m_cap, m_capf, s1a, s2a, s1b, s2b, m_prev;
  int ppoint, selv, do_clr;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_par = 0; m_cap = 0; m_capf = 0;
      s1a = 0; s2a = 0; s1b = 0; s2b = 0; m_prev = 0;
      first = 1;
    end else begin
      ppoint = int'(cmp_p) * 128;
      selv = cap_src ? s2b : s2a;
      if (mode == 2'd3 && selv == 1 && m_prev == 0) begin
        m_cap = m_cnt; m_capf = 1;
      end else m_capf = 0;
      m_prev = selv;
      s2a = s1a; s1a = int'(trig_a);
      s2b = s1b; s1b = int'(trig_b);
      if (mode != 2'd1) m_par = 0;
      else if (m_cnt == int'(cmp_a)) m_par = 1 - m_par;
      do_clr = 0;
      if (mode <= 2'd1) begin
        if (clr_sel) do_clr = (m_cnt == int'(cmp_a));
        else         do_clr = (cmp_p != 0 && m_cnt == ppoint);
      end else if (mode == 2'd2) do_clr = (cmp_p != 0 && m_cnt == ppoint);
      m_cnt = do_clr ? 0 : (m_cnt + 1) % WRAP;
    end
  end

  always @(negedge clk) begin
    string ctag, ptag;
    int exp_pin;
    if (rst_n && !done) begin
      if (first) ctag = "R2";
      else if (mode >= 2'd2) ctag = "R5";
      else if (clr_sel) ctag = "R3";
      else ctag = "R4";
      check({ctag, " counter"}, int'({cnt_hi, cnt_lo}), m_cnt);
      check("R1 hi upper bits", int'(cnt_hi[7:2]), 0);
      check("R6 flag_a", int'(flag_a), int'(m_cnt == int'(cmp_a)));
      check("R6 flag_p", int'(flag_p), int'(cmp_p != 0 && m_cnt == int'(cmp_p) * 128));
      case (mode)
        2'd1: begin exp_pin = (int'(out_ctl) ^ m_par) ^ int'(out_pol); ptag = "R7"; end
        2'd2: begin
          exp_pin = ((m_cnt < int'(cmp_a)) ? int'(out_ctl) : 1 - int'(out_ctl)) ^ int'(out_pol);
          ptag = "R8";
        end
        default: begin exp_pin = 0; ptag = "R9"; end
      endcase
      check({ptag, " tout0"}, int'(tout0), exp_pin);
      check("R11 tout1", int'(tout1), int'(tout0));
      check(first ? "R2 cap_val" : "R10 cap_val", int'(cap_val), m_cap);
      check("R10 cap_flag", int'(cap_flag), m_capf);
      first = 0;
    end
  end

  task automatic go(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    go(3);
    rst_n = 1'b1;
    // R4: overflow wrap with P=0, timer mode
    go(1100);
    // R3: A clears the counter
    clr_sel = 1; cmp_a = 10'd20; go(60);
    // R4/R6: P=1 period, ctl/pol set but timer mode keeps pins low (R9)
    clr_sel = 0; cmp_p = 3'd1; out_ctl = 1; out_pol = 1; go(300);
    // R7: compare toggles, A=10 clearing
    mode = 2'd1; clr_sel = 1; cmp_a = 10'd10; out_pol = 0; go(60);
    out_pol = 1; go(30);
    out_ctl = 0; go(30);
    // R4 inside compare mode with P clearing
    clr_sel = 0; cmp_a = 10'd50; go(300);
    // R5/R8: PWM, clr_sel ignored
    mode = 2'd2; clr_sel = 1; cmp_a = 10'd40; cmp_p = 3'd1; out_ctl = 0; out_pol = 0; go(300);
    out_ctl = 1; out_pol = 1; go(150);
    cmp_a = 10'd0; go(150);
    cmp_a = 10'd1000; go(150);
    // R10: capture mode, free running, trig_b ignored while trig_a selected
    mode = 2'd3; clr_sel = 1; cmp_a = 10'd5; cmp_p = 3'd2; cap_src = 0; go(20);
    trig_b = 1; go(8); trig_b = 0; go(8);
    trig_a = 1; go(8); trig_a = 0; go(30);
    trig_a = 1; go(3); trig_a = 0; go(10);
    cap_src = 1; go(10);
    trig_b = 1; go(6); trig_b = 0; go(6);
    trig_a = 1; go(6); trig_a = 0; go(1100);
    // Back to timer after capture: pins low (R9)
    mode = 2'd0; go(40);
    finish_run();
  end

endmodule